// File: doc/BRIEF.md
# Serial Port Register Block

This block is the bus-facing half of a serial port. A processor reaches four 32-bit registers through a simple select/write bus: control, receive data, transmit data and status. Characters written to the transmit data register queue in a transmit FIFO until a separate frame engine takes them. Characters the frame engine delivers queue in a receive FIFO until software reads them from the receive data register.

The status register reports several things. It shows whether each FIFO is full or empty, and it has one fill-level field that can show either FIFO. It holds sticky error flags and two interrupt-pending flags. The pending and error flags are cleared by writing ones to them. A single active-high interrupt line combines the two pending flags with their enables.

The frame engine sees the stored control word, so it can read the character format, the port enable and the loopback setting. Serial line timing, clock generation and DMA are not part of this block.

Top module: `serport_regs`

## Requirements
- R1: Address bits 3:2 select the register: 0 is control, 1 is receive data, 2 is transmit data, 3 is status. Control resets to zero. Only control bits 0-2, 4-6, 12, 14, 15, 18, 19 and 20 are stored; every other bit reads back as zero. The stored word drives `cfg_ctrl`.
- R2: A write to transmit data pushes `bus_wdata[7:0]` into the transmit FIFO. The frame engine sees the oldest character on `tx_data` and removes it with `tx_pop`. Characters leave in the order they were written.
- R3: A write to transmit data while the transmit FIFO is full, with no pop in the same cycle, is dropped and sets status bit 3.
- R4: A receive-data read returns the oldest received character in bits 7:0, with zeros above, and removes it from the FIFO. Status bit 5 is set while the receive FIFO is empty.
- R5: A receive-data read while the receive FIFO is empty returns zero and leaves the FIFO unchanged.
- R6: A character the frame engine pushes while the receive FIFO is full, with no read in the same cycle, is dropped and sets status bit 2. A push with `rx_err` high sets status bit 4.
- R7: Writing a one to status bits 0-4 clears that bit. Writing zero leaves the bit unchanged. All other status bits are read-only.
- R8: Status bit 0 (receive pending) is set one cycle after the receive FIFO is non-empty. Status bit 1 (transmit pending) is set one cycle after the transmit FIFO has room. Each pending bit stays set until it is cleared by a write of one. If its condition still holds when the clear is written, the bit stays set.
- R9: `irq` is high exactly when (bit 0 AND control bit 18) OR (bit 1 AND control bit 19).
- R10: Status bits 16:11 show the transmit FIFO fill level when control bit 14 is one, and the receive FIFO fill level when it is zero.
- R11: While control bit 15 (port enable) is zero, `tx_avail` is low, `tx_pop` has no effect, and `rx_push` is ignored.
- R12: The transmit FIFO holds exactly `TX_DEPTH` characters. Status bit 6 is set when it is full and bit 10 is set when it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq | output | 1 | Level-high interrupt |
| cfg_ctrl | output | 32 | Stored control word, for the frame engine |
| tx_data | output | 8 | Oldest transmit character |
| tx_avail | output | 1 | A transmit character is ready and the port is enabled |
| tx_pop | input | 1 | Frame engine takes `tx_data` |
| rx_push | input | 1 | Frame engine delivers a character |
| rx_data | input | 8 | Delivered character |
| rx_err | input | 1 | Delivered character had a framing, parity or break error |

## Verification
The bench builds the block with a 16-entry transmit FIFO and a 4-entry receive FIFO. The small receive depth makes overrun and the full-level value easy to reach under random traffic. The 16-entry transmit side still exercises the larger fill-level values and the full-flag boundary. Random bus traffic, pops and pushes often land in the same cycle. This exposes simultaneous push and pop on a full FIFO, and pending-bit clears that race a still-true condition.

// File: rtl/serport_pkg.sv
package serport_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_RXD  = 2'd1,
        REG_TXD  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    localparam int CHAR_W = 8;
    localparam int LVL_W  = 6;

    // writable control bits
    localparam logic [31:0] CTRL_MASK = 32'h001C_D077;

    localparam int CB_LVLSEL = 14;
    localparam int CB_EN     = 15;
    localparam int CB_RXIE   = 18;
    localparam int CB_TXIE   = 19;

    localparam int SB_RIP     = 0;
    localparam int SB_TIP     = 1;
    localparam int SB_OVR     = 2;
    localparam int SB_TXERR   = 3;
    localparam int SB_RXERR   = 4;
    localparam int SB_RXEMPTY = 5;
    localparam int SB_TXFULL  = 6;
    localparam int SB_TXEMPTY = 10;
    localparam int SB_LVL_LO  = 11;

endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [WIDTH-1:0]               wdata,
    input  logic                           pop,
    output logic [WIDTH-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [IW-1:0] wr;
        logic [IW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign count = st_q.cnt;
    assign rdata = mem_q[st_q.rd];

    always_comb begin
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        st_d    = st_q;
        if (do_push) st_d.wr = wrap_inc(st_q.wr);
        if (do_pop)  st_d.rd = wrap_inc(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata;
    end

    // R12
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

endmodule

// File: rtl/serport_irq.sv
module serport_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_cond,
    input  logic       tx_cond,
    input  logic [1:0] clr,
    input  logic       rx_ie,
    input  logic       tx_ie,
    output logic [1:0] pend,
    output logic       irq
);
    typedef struct packed {
        logic tip;
        logic rip;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d.rip = rx_cond | (st_q.rip & ~clr[0]);
        st_d.tip = tx_cond | (st_q.tip & ~clr[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = {st_q.tip, st_q.rip};
    assign irq  = (st_q.rip & rx_ie) | (st_q.tip & tx_ie);

    // R8
    rip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !clr[0]) |=> pend[0]);

    // R8
    rip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cond |=> pend[0]);

    // R8
    tip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cond |=> pend[1]);

endmodule

// File: rtl/serport_regs.sv
module serport_regs
    import serport_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [31:0]       cfg_ctrl,
    output logic [7:0]        tx_data,
    output logic              tx_avail,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [7:0]        rx_data,
    input  logic              rx_err
);
    localparam int TXC_W = $clog2(TX_DEPTH + 1);
    localparam int RXC_W = $clog2(RX_DEPTH + 1);

    typedef struct packed {
        logic [31:0] ctrl;
        logic        ovr;
        logic        txerr;
        logic        rxerr;
    } regs_t;

    regs_t st_d, st_q;

    reg_sel_e   rsel;
    logic       addr_ok;
    logic       wr_ctrl, wr_txd, wr_stat, rd_rxd, rd_any;
    logic       port_en;
    logic [4:0] w1c;

    logic [CHAR_W-1:0] tx_head, rx_head;
    logic [TXC_W-1:0]  tx_cnt;
    logic [RXC_W-1:0]  rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_take, rx_take;
    logic [1:0]       pend;
    logic [LVL_W-1:0] lvl;
    logic [31:0]      status_w;

    assign rsel    = reg_sel_e'(bus_addr[3:2]);
    assign addr_ok = (bus_addr >> 4) == '0;
    assign rd_any  = bus_sel && !bus_wr && addr_ok;
    assign wr_ctrl = bus_sel && bus_wr && addr_ok && (rsel == REG_CTRL);
    assign wr_txd  = bus_sel && bus_wr && addr_ok && (rsel == REG_TXD);
    assign wr_stat = bus_sel && bus_wr && addr_ok && (rsel == REG_STAT);
    assign rd_rxd  = rd_any && (rsel == REG_RXD);
    assign w1c     = wr_stat ? bus_wdata[4:0] : 5'd0;

    assign port_en = st_q.ctrl[CB_EN];
    assign tx_take = tx_pop && port_en;
    assign rx_take = rx_push && port_en;

    serport_fifo #(.DEPTH(TX_DEPTH), .WIDTH(CHAR_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_txd),
        .wdata (bus_wdata[CHAR_W-1:0]),
        .pop   (tx_take),
        .rdata (tx_head),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    serport_fifo #(.DEPTH(RX_DEPTH), .WIDTH(CHAR_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_take),
        .wdata (rx_data),
        .pop   (rd_rxd),
        .rdata (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    serport_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_cond (!rx_empty),
        .tx_cond (!tx_full),
        .clr     (w1c[1:0]),
        .rx_ie   (st_q.ctrl[CB_RXIE]),
        .tx_ie   (st_q.ctrl[CB_TXIE]),
        .pend    (pend),
        .irq     (irq)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = bus_wdata & CTRL_MASK;
        st_d.ovr   = (rx_take && rx_full && !rd_rxd) | (st_q.ovr & ~w1c[2]);
        st_d.txerr = (wr_txd && tx_full && !tx_take) | (st_q.txerr & ~w1c[3]);
        st_d.rxerr = (rx_take && rx_err) | (st_q.rxerr & ~w1c[4]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.ctrl[CB_LVLSEL] ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);

    always_comb begin
        status_w                        = '0;
        status_w[SB_RIP]                = pend[0];
        status_w[SB_TIP]                = pend[1];
        status_w[SB_OVR]                = st_q.ovr;
        status_w[SB_TXERR]              = st_q.txerr;
        status_w[SB_RXERR]              = st_q.rxerr;
        status_w[SB_RXEMPTY]            = rx_empty;
        status_w[SB_TXFULL]             = tx_full;
        status_w[SB_TXEMPTY]            = tx_empty;
        status_w[SB_LVL_LO +: LVL_W]    = lvl;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            case (rsel)
                REG_CTRL: bus_rdata = st_q.ctrl;
                REG_RXD:  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
                REG_STAT: bus_rdata = status_w;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign cfg_ctrl = st_q.ctrl;
    assign tx_data  = tx_head;
    assign tx_avail = port_en && !tx_empty;

    // R5
    rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty && !rx_take) |=> rx_empty);

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !w1c[2]) |=> st_q.ovr);

    // R11
    disabled_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !rd_rxd) |=> $stable(rx_cnt));

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_take && rx_full && !rd_rxd) |=> st_q.ovr);

endmodule

// File: tb/tb_serport_regs.sv
module tb_serport_regs;
    localparam int CLK_PERIOD = 10;
    localparam int TXD = 16;
    localparam int RXD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [31:0] cfg_ctrl;
    logic [7:0]  tx_data;
    logic        tx_avail;
    logic        tx_pop = 1'b0, rx_push = 1'b0, rx_err = 1'b0;
    logic [7:0]  rx_data = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_rd;

    // model state
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];
    logic [31:0] m_ctrl = '0;
    logic m_rip = 0, m_tip = 0, m_ovr = 0, m_txerr = 0, m_rxerr = 0;

    serport_regs #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cfg_ctrl(cfg_ctrl), .tx_data(tx_data), .tx_avail(tx_avail),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .rx_err(rx_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[0] = m_rip; s[1] = m_tip; s[2] = m_ovr; s[3] = m_txerr; s[4] = m_rxerr;
        s[5] = (rxq.size() == 0);
        s[6] = (txq.size() == TXD);
        s[10] = (txq.size() == 0);
        s[16:11] = m_ctrl[14] ? 6'(txq.size()) : 6'(rxq.size());
        return s;
    endfunction

    // one bus/engine cycle; entered and left at a falling edge
    task automatic step(input logic s, input logic w, input logic [3:0] a,
                        input logic [31:0] d, input logic tp, input logic rp,
                        input logic [7:0] rd, input logic re);
        logic en, rx_pop_ok, tx_pop_ok, rip_c, tip_c;
        logic [4:0] clr;
        logic [31:0] exp_rd;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        tx_pop = tp; rx_push = rp; rx_data = rd; rx_err = re;
        #1;
        en = m_ctrl[15];
        last_rd = bus_rdata;
        if (s && !w) begin
            case (a)
                4'h0: begin exp_rd = m_ctrl; chk("R1 ctrl read", bus_rdata, exp_rd); end
                4'h4: begin exp_rd = (rxq.size() > 0) ? {24'd0, rxq[0]} : 32'd0;
                            chk("R4 rx read", bus_rdata, exp_rd); end
                4'hC: begin exp_rd = exp_status(); chk("R7 status read", bus_rdata, exp_rd); end
                default: ;
            endcase
        end
        chk("R9 irq", {31'd0, irq}, {31'd0, (m_rip & m_ctrl[18]) | (m_tip & m_ctrl[19])});
        chk("R11 tx_avail", {31'd0, tx_avail}, {31'd0, en && (txq.size() > 0)});
        if (en && txq.size() > 0) chk("R2 tx_data", {24'd0, tx_data}, {24'd0, txq[0]});
        // model update from pre-edge state
        rip_c = (rxq.size() > 0);
        tip_c = (txq.size() < TXD);
        clr = (s && w && a == 4'hC) ? d[4:0] : 5'd0;
        rx_pop_ok = s && !w && a == 4'h4 && rxq.size() > 0;
        tx_pop_ok = tp && en && txq.size() > 0;
        m_rip = rip_c | (m_rip & ~clr[0]);
        m_tip = tip_c | (m_tip & ~clr[1]);
        m_ovr   = (rp && en && rxq.size() == RXD && !rx_pop_ok) | (m_ovr & ~clr[2]);
        m_txerr = (s && w && a == 4'h8 && txq.size() == TXD && !tx_pop_ok) | (m_txerr & ~clr[3]);
        m_rxerr = (rp && en && re) | (m_rxerr & ~clr[4]);
        if (rx_pop_ok) void'(rxq.pop_front());
        if (tx_pop_ok) void'(txq.pop_front());
        if (rp && en && (rxq.size() < RXD)) rxq.push_back(rd);
        if (s && w && a == 4'h8 && txq.size() < TXD) txq.push_back(d[7:0]);
        if (s && w && a == 4'h0) m_ctrl = d & 32'h001C_D077;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0, 8'h0, 0);
    endtask
    task automatic rd_reg(input logic [3:0] a);
        step(1, 0, a, 32'h0, 0, 0, 8'h0, 0);
    endtask
    task automatic idle();
        step(0, 0, 4'h0, 32'h0, 0, 0, 8'h0, 0);
    endtask
    task automatic tpop();
        step(0, 0, 4'h0, 32'h0, 1, 0, 8'h0, 0);
    endtask
    task automatic rpush(input logic [7:0] v, input logic e);
        step(0, 0, 4'h0, 32'h0, 0, 1, v, e);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // reset state
        repeat (2) @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 4'hC; #1;
        chk("R12 reset status", bus_rdata, 32'h0000_0420);
        bus_addr = 4'h0; #1;
        chk("R1 reset ctrl", bus_rdata, 32'h0);
        chk("R9 reset irq", {31'd0, irq}, 32'd0);
        bus_sel = 0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1 masking
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_reg(4'h0);
        chk("R1 masked ctrl", last_rd, 32'h001C_D077);
        chk("R1 cfg_ctrl", cfg_ctrl, 32'h001C_D077);
        wr_reg(4'h0, 32'h0);

        // R11 disabled port
        rpush(8'h77, 0);
        rd_reg(4'hC);
        chk("R11 rx ignored", {31'd0, last_rd[5]}, 32'd1);
        wr_reg(4'h8, 32'h41);
        idle();
        chk("R11 no tx_avail", {31'd0, tx_avail}, 32'd0);
        tpop();
        wr_reg(4'h0, 32'h0000_C000);
        idle();
        chk("R2 first char", {24'd0, tx_data}, 32'h41);
        tpop();

        // R12 / R3 transmit fill
        for (int i = 0; i < TXD; i++) wr_reg(4'h8, 32'h10 + i);
        rd_reg(4'hC);
        chk("R12 tx full bit", {31'd0, last_rd[6]}, 32'd1);
        chk("R10 tx level", {26'd0, last_rd[16:11]}, 32'd16);
        wr_reg(4'h8, 32'hEE);
        rd_reg(4'hC);
        chk("R3 tx drop flag", {31'd0, last_rd[3]}, 32'd1);
        for (int i = 0; i < TXD; i++) begin
            chk("R2 tx order", {24'd0, tx_data}, 32'h10 + i);
            tpop();
        end
        rd_reg(4'hC);
        chk("R12 tx empty bit", {31'd0, last_rd[10]}, 32'd1);

        // receive side, level shows rx
        wr_reg(4'h0, 32'h0000_8000);
        for (int i = 0; i < RXD + 1; i++) rpush(8'hA0 + i, 0);
        rd_reg(4'hC);
        chk("R6 overrun flag", {31'd0, last_rd[2]}, 32'd1);
        chk("R10 rx level", {26'd0, last_rd[16:11]}, RXD);
        chk("R8 rx pending", {31'd0, last_rd[0]}, 32'd1);
        for (int i = 0; i < RXD; i++) begin
            rd_reg(4'h4);
            chk("R4 rx order", last_rd, 32'hA0 + i);
        end
        rd_reg(4'h4);
        chk("R5 empty read", last_rd, 32'h0);
        rd_reg(4'hC);
        chk("R8 rip sticky", {31'd0, last_rd[0]}, 32'd1);
        chk("R4 rx empty bit", {31'd0, last_rd[5]}, 32'd1);

        // R7 write-one-to-clear
        wr_reg(4'hC, 32'h0);
        rd_reg(4'hC);
        chk("R7 zero write keeps", {31'd0, last_rd[2]}, 32'd1);
        wr_reg(4'hC, 32'hFFFF_FFFF);
        rd_reg(4'hC);
        chk("R8 set wins over clear", {27'd0, last_rd[4:0]}, 32'h2);
        chk("R7 ro bits kept", {31'd0, last_rd[10]}, 32'd1);

        // R6 error flag and R9 interrupt
        rpush(8'h55, 1);
        rd_reg(4'hC);
        chk("R6 rx error flag", {31'd0, last_rd[4]}, 32'd1);
        wr_reg(4'h0, 32'h0004_8000);
        idle();
        chk("R9 rx irq", {31'd0, irq}, 32'd1);
        rd_reg(4'h4);
        wr_reg(4'hC, 32'h1);
        idle();
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        wr_reg(4'h0, 32'h0008_8000);
        idle();
        chk("R9 tx irq", {31'd0, irq}, 32'd1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int op;
            logic tp, rp;
            logic [31:0] d;
            op = $urandom_range(0, 9);
            tp = ($urandom_range(0, 3) == 0);
            rp = ($urandom_range(0, 3) == 0);
            d  = $urandom;
            case (op)
                0, 1: step(1, 1, 4'h8, d, tp, rp, d[15:8], d[16] & d[17]);
                2:    step(0, 0, 4'h0, d, 1, rp, d[15:8], 0);
                3, 4: step(0, 0, 4'h0, d, tp, 1, d[15:8], d[18:16] == 3'd0);
                5:    step(1, 0, 4'h4, d, tp, rp, d[15:8], 0);
                6:    step(1, 0, 4'hC, d, tp, rp, d[15:8], 0);
                7:    step(1, 0, 4'h0, d, tp, rp, d[15:8], 0);
                8:    step(1, 1, 4'hC, d, tp, rp, d[15:8], 0);
                default: begin
                    if ($urandom_range(0, 3) == 0)
                        step(1, 1, 4'h0, d | (($urandom_range(0, 7) != 0) ? 32'h8000 : 32'h0),
                             tp, rp, d[15:8], 0);
                    else
                        step(0, 0, 4'h0, d, tp, rp, d[15:8], 0);
                end
            endcase
        end
        idle();
        finish_run();
    end
endmodule